// File: doc/BRIEF.md
# Lifting-based plane rotation pair

This block holds two matched fixed-point datapaths. The first rotates a pair of signed samples through a fixed angle. The second undoes that rotation. Each datapath is built from three shear (lifting) steps. A step leaves one rail as it is and adds to the other rail a scaled copy of the first one. The scaling is an integer multiply followed by an arithmetic right shift of `CWL` bits, which truncates toward minus infinity.

The forward path applies the coefficient `P` to rail A, then `U` to rail B, then `P` to rail A again. The inverse path applies the same three steps in the same rail order, but each one subtracts where the forward step adds. Every step of the inverse sees the same unchanged rail that the matching forward step saw. It therefore recomputes the same truncated term and removes it exactly, so the pair reconstructs its input bit for bit.

Both paths accept one sample pair per clock. Each has a latency of three cycles, one register per step. Coefficients are parameters: `P_COEF / 2^CWL` approximates (cos a − 1)/sin a, and `U_COEF / 2^CWL` approximates sin a. Internal rails carry `GUARD` extra bits so that no step overflows for full-range inputs.

Top module: `rotlift_pair`

## Requirements
- R1: Forward data, with floor meaning truncation toward minus infinity:
  - A1 = A + floor(P_COEF·B / 2^CWL)
  - B1 = B + floor(U_COEF·A1 / 2^CWL)
  - A2 = A1 + floor(P_COEF·B1 / 2^CWL)
  - The forward outputs are (A2, B1).
- R2: Inverse data:
  - A1 = A − floor(P_COEF·B / 2^CWL)
  - B1 = B − floor(U_COEF·A1 / 2^CWL)
  - A2 = A1 − floor(P_COEF·B1 / 2^CWL)
  - The inverse outputs are (A2, B1).
- R3: Feeding the forward outputs into the inverse input returns the original forward input pair exactly, for any IN_W-bit signed inputs.
- R4: Each output valid equals its input valid delayed by exactly three clock cycles. Output data is meaningful only while the output valid is high.
- R5: The scaling truncates toward minus infinity. For example, a product of −1 shifted by CWL gives −1, not 0.
- R6: While rst_n is low, and in the first cycle after it is released, both output valids are 0 and all output data is 0.
- R7: The rails are RAIL_W = IN_W + GUARD bits wide. No step overflows for any IN_W-bit input pair, including the extreme values −2^(IN_W−1) and 2^(IN_W−1)−1.
- R8: Both paths accept a new valid sample pair on every clock cycle with no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fwd_in_valid | input | 1 | Forward input pair valid |
| fwd_in_a | input | IN_W | Forward input rail A, signed |
| fwd_in_b | input | IN_W | Forward input rail B, signed |
| fwd_out_valid | output | 1 | Forward output valid |
| fwd_out_a | output | RAIL_W | Forward output rail A, signed |
| fwd_out_b | output | RAIL_W | Forward output rail B, signed |
| inv_in_valid | input | 1 | Inverse input pair valid |
| inv_in_a | input | RAIL_W | Inverse input rail A, signed |
| inv_in_b | input | RAIL_W | Inverse input rail B, signed |
| inv_out_valid | output | 1 | Inverse output valid |
| inv_out_a | output | RAIL_W | Inverse output rail A, signed |
| inv_out_b | output | RAIL_W | Inverse output rail B, signed |

## Verification
The forward path is driven with four input patterns:
- The eight extreme corner pairs, which show whether the guard bits are wide enough.
- Small negative values, whose products land just below zero and so separate floor truncation from truncation toward zero.
- Random full-range pairs with random valid gaps, which show whether the valid timing is right and whether the coefficients are applied in the right order.
- Unbroken back-to-back streams, which would show any lost throughput.

With the inverse chained behind the forward path, every random pair must come back unchanged; a sign or ordering slip in either path breaks this. Driving the inverse on its own, with arbitrary pairs compared against a behavioural model, catches an inverse that happens to cancel the forward errors.

// File: rtl/rotlift_pkg.sv
package rotlift_pkg;

    // Which rail a lifting step modifies.
    typedef enum logic {
        RAIL_A = 1'b0,
        RAIL_B = 1'b1
    } rail_sel_e;

    // Forward steps add the scaled term; inverse steps subtract it.
    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_INV = 1'b1
    } lift_dir_e;

endpackage

// File: rtl/rotlift_step.sv
module rotlift_step
    import rotlift_pkg::*;
#(
    parameter int                          RAIL_W = 15,
    parameter int                          COEF_W = 10,
    parameter int                          CWL    = 8,
    parameter logic signed [COEF_W-1:0]    COEF   = '0,
    parameter rail_sel_e                   TARGET = RAIL_A,
    parameter lift_dir_e                   DIR    = DIR_FWD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [RAIL_W-1:0] in_a,
    input  logic signed [RAIL_W-1:0] in_b,
    output logic                     out_valid,
    output logic signed [RAIL_W-1:0] out_a,
    output logic signed [RAIL_W-1:0] out_b
);
    localparam int PROD_W = RAIL_W + COEF_W;
    localparam int SUM_W  = RAIL_W + 1;

    typedef struct packed {
        logic                     valid;
        logic signed [RAIL_W-1:0] a;
        logic signed [RAIL_W-1:0] b;
    } stage_t;

    stage_t st_d, st_q;

    logic signed [RAIL_W-1:0] src_rail;   // rail that is only read
    logic signed [RAIL_W-1:0] dst_rail;   // rail that is updated
    logic signed [PROD_W-1:0] prod;
    logic signed [RAIL_W-1:0] delta;
    logic signed [SUM_W-1:0]  sum_w;

    always_comb begin
        src_rail = (TARGET == RAIL_A) ? in_b : in_a;
        dst_rail = (TARGET == RAIL_A) ? in_a : in_b;
        prod     = PROD_W'(src_rail) * PROD_W'(COEF);
        // Arithmetic shift gives floor division by 2^CWL.
        delta    = RAIL_W'(prod >>> CWL);
        if (DIR == DIR_FWD) begin
            sum_w = SUM_W'(dst_rail) + SUM_W'(delta);
        end else begin
            sum_w = SUM_W'(dst_rail) - SUM_W'(delta);
        end
        st_d.valid = in_valid;
        st_d.a     = (TARGET == RAIL_A) ? sum_w[RAIL_W-1:0] : in_a;
        st_d.b     = (TARGET == RAIL_B) ? sum_w[RAIL_W-1:0] : in_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_a     = st_q.a;
    assign out_b     = st_q.b;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (sum_w[SUM_W-1] == sum_w[SUM_W-2])); // R7

    AST_STEP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R4

    AST_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R4

    AST_KEEP_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((TARGET == RAIL_A) ? (out_b == $past(in_b))
                                         : (out_a == $past(in_a)))); // R1
endmodule

// File: rtl/rotlift_unit.sv
module rotlift_unit
    import rotlift_pkg::*;
#(
    parameter int                          RAIL_W = 15,
    parameter int                          COEF_W = 10,
    parameter int                          CWL    = 8,
    parameter logic signed [COEF_W-1:0]    P_COEF = '0,
    parameter logic signed [COEF_W-1:0]    U_COEF = '0,
    parameter lift_dir_e                   DIR    = DIR_FWD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [RAIL_W-1:0] in_a,
    input  logic signed [RAIL_W-1:0] in_b,
    output logic                     out_valid,
    output logic signed [RAIL_W-1:0] out_a,
    output logic signed [RAIL_W-1:0] out_b
);
    localparam int N_STEPS = 3;

    logic                     v_w [0:N_STEPS];
    logic signed [RAIL_W-1:0] a_w [0:N_STEPS];
    logic signed [RAIL_W-1:0] b_w [0:N_STEPS];

    assign v_w[0] = in_valid;
    assign a_w[0] = in_a;
    assign b_w[0] = in_b;

    // Step order P on A, U on B, P on A: the same in both directions.
    for (genvar k = 0; k < N_STEPS; k++) begin : g_step
        rotlift_step #(
            .RAIL_W (RAIL_W),
            .COEF_W (COEF_W),
            .CWL    (CWL),
            .COEF   ((k == 1) ? U_COEF : P_COEF),
            .TARGET ((k == 1) ? RAIL_B : RAIL_A),
            .DIR    (DIR)
        ) u_step (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (v_w[k]),
            .in_a      (a_w[k]),
            .in_b      (b_w[k]),
            .out_valid (v_w[k+1]),
            .out_a     (a_w[k+1]),
            .out_b     (b_w[k+1])
        );
    end

    assign out_valid = v_w[N_STEPS];
    assign out_a     = a_w[N_STEPS];
    assign out_b     = b_w[N_STEPS];

    // Cycles since reset, saturating, so the latency check never looks before reset.
    logic [1:0] since_rst_d, since_rst_q;

    always_comb begin
        since_rst_d = (since_rst_q == 2'd3) ? since_rst_q : since_rst_q + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst_q <= '0;
        end else begin
            since_rst_q <= since_rst_d;
        end
    end

    AST_UNIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R4

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == 2'd0) |-> (!out_valid && out_a == '0 && out_b == '0)); // R6
endmodule

// File: rtl/rotlift_pair.sv
module rotlift_pair
    import rotlift_pkg::*;
#(
    parameter int                          IN_W   = 12,
    parameter int                          GUARD  = 3,
    parameter int                          CWL    = 8,
    parameter int                          COEF_W = CWL + 2,
    parameter logic signed [COEF_W-1:0]    P_COEF = -COEF_W'(106),
    parameter logic signed [COEF_W-1:0]    U_COEF = COEF_W'(181),
    localparam int                         RAIL_W = IN_W + GUARD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fwd_in_valid,
    input  logic signed [IN_W-1:0]   fwd_in_a,
    input  logic signed [IN_W-1:0]   fwd_in_b,
    output logic                     fwd_out_valid,
    output logic signed [RAIL_W-1:0] fwd_out_a,
    output logic signed [RAIL_W-1:0] fwd_out_b,
    input  logic                     inv_in_valid,
    input  logic signed [RAIL_W-1:0] inv_in_a,
    input  logic signed [RAIL_W-1:0] inv_in_b,
    output logic                     inv_out_valid,
    output logic signed [RAIL_W-1:0] inv_out_a,
    output logic signed [RAIL_W-1:0] inv_out_b
);
    logic signed [RAIL_W-1:0] fwd_a_ext;
    logic signed [RAIL_W-1:0] fwd_b_ext;

    assign fwd_a_ext = RAIL_W'(fwd_in_a);
    assign fwd_b_ext = RAIL_W'(fwd_in_b);

    rotlift_unit #(
        .RAIL_W (RAIL_W),
        .COEF_W (COEF_W),
        .CWL    (CWL),
        .P_COEF (P_COEF),
        .U_COEF (U_COEF),
        .DIR    (DIR_FWD)
    ) u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (fwd_in_valid),
        .in_a      (fwd_a_ext),
        .in_b      (fwd_b_ext),
        .out_valid (fwd_out_valid),
        .out_a     (fwd_out_a),
        .out_b     (fwd_out_b)
    );

    rotlift_unit #(
        .RAIL_W (RAIL_W),
        .COEF_W (COEF_W),
        .CWL    (CWL),
        .P_COEF (P_COEF),
        .U_COEF (U_COEF),
        .DIR    (DIR_INV)
    ) u_inv (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (inv_in_valid),
        .in_a      (inv_in_a),
        .in_b      (inv_in_b),
        .out_valid (inv_out_valid),
        .out_a     (inv_out_a),
        .out_b     (inv_out_b)
    );
endmodule

// File: tb/rotlift_pair_bench.sv
module rotlift_pair_bench;
    localparam int  CLK_PERIOD = 10;
    localparam int  IN_W   = 12;
    localparam int  GUARD  = 3;
    localparam int  CWL    = 8;
    localparam int  COEF_W = CWL + 2;
    localparam int  RAIL_W = IN_W + GUARD;
    localparam longint PC = -106;
    localparam longint UC = 181;
    localparam longint IN_MAX = (64'sd1 <<< (IN_W - 1)) - 1;
    localparam longint IN_MIN = -(64'sd1 <<< (IN_W - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fwd_in_valid = 1'b0;
    logic signed [IN_W-1:0]   fwd_in_a = '0;
    logic signed [IN_W-1:0]   fwd_in_b = '0;
    logic fwd_out_valid;
    logic signed [RAIL_W-1:0] fwd_out_a, fwd_out_b;
    logic direct_mode = 1'b0;
    logic d_valid = 1'b0;
    logic signed [RAIL_W-1:0] d_a = '0;
    logic signed [RAIL_W-1:0] d_b = '0;
    logic inv_in_valid;
    logic signed [RAIL_W-1:0] inv_in_a, inv_in_b;
    logic inv_out_valid;
    logic signed [RAIL_W-1:0] inv_out_a, inv_out_b;

    assign inv_in_valid = direct_mode ? d_valid : fwd_out_valid;
    assign inv_in_a     = direct_mode ? d_a : fwd_out_a;
    assign inv_in_b     = direct_mode ? d_b : fwd_out_b;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rotlift_pair #(
        .IN_W (IN_W), .GUARD (GUARD), .CWL (CWL), .COEF_W (COEF_W),
        .P_COEF (-COEF_W'(106)), .U_COEF (COEF_W'(181))
    ) u_rotlift_pair (
        .clk (clk), .rst_n (rst_n),
        .fwd_in_valid (fwd_in_valid), .fwd_in_a (fwd_in_a), .fwd_in_b (fwd_in_b),
        .fwd_out_valid (fwd_out_valid), .fwd_out_a (fwd_out_a), .fwd_out_b (fwd_out_b),
        .inv_in_valid (inv_in_valid), .inv_in_a (inv_in_a), .inv_in_b (inv_in_b),
        .inv_out_valid (inv_out_valid), .inv_out_a (inv_out_a), .inv_out_b (inv_out_b)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string tag_fdata = "R1";
    string tag_valid = "R4";

    // Model queues: one entry per cycle.
    bit     fq_v[$]; longint fq_a[$]; longint fq_b[$];
    bit     iq_v[$]; longint iq_a[$]; longint iq_b[$];
    bit     rq_v[$]; longint rq_a[$]; longint rq_b[$];

    function automatic longint lstep(longint dst, longint src, longint c, bit sub);
        longint t;
        t = (src * c) >>> CWL;
        return sub ? dst - t : dst + t;
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare, then drive new inputs, then record the model for this cycle.
    task automatic cycle(bit fv, longint fa, longint fb, bit dv, longint da, longint db);
        longint a1, b1, a2;
        @(negedge clk);
        if (fq_v.size() == 3) begin
            bit ev; longint ea, eb;
            ev = fq_v.pop_front(); ea = fq_a.pop_front(); eb = fq_b.pop_front();
            check(tag_valid, "fwd valid", longint'(fwd_out_valid), longint'(ev));
            if (ev) begin
                check(tag_fdata, "fwd a", longint'(fwd_out_a), ea);
                check(tag_fdata, "fwd b", longint'(fwd_out_b), eb);
            end
        end
        if (iq_v.size() == 3) begin
            bit ev; longint ea, eb;
            ev = iq_v.pop_front(); ea = iq_a.pop_front(); eb = iq_b.pop_front();
            check("R4", "inv valid", longint'(inv_out_valid), longint'(ev));
            if (ev) begin
                check("R2", "inv a", longint'(inv_out_a), ea);
                check("R2", "inv b", longint'(inv_out_b), eb);
            end
        end
        if (rq_v.size() == 6) begin
            bit ev; longint ea, eb;
            ev = rq_v.pop_front(); ea = rq_a.pop_front(); eb = rq_b.pop_front();
            if (ev) begin
                check("R3", "round trip a", longint'(inv_out_a), ea);
                check("R3", "round trip b", longint'(inv_out_b), eb);
            end
        end
        fwd_in_valid = fv;
        fwd_in_a = IN_W'(fa);
        fwd_in_b = IN_W'(fb);
        d_valid = dv;
        d_a = RAIL_W'(da);
        d_b = RAIL_W'(db);
        #1;
        a1 = lstep(fa, fb, PC, 1'b0);
        b1 = lstep(fb, a1, UC, 1'b0);
        a2 = lstep(a1, b1, PC, 1'b0);
        fq_v.push_back(fv); fq_a.push_back(a2); fq_b.push_back(b1);
        rq_v.push_back(fv && !direct_mode); rq_a.push_back(fa); rq_b.push_back(fb);
        a1 = lstep(longint'(inv_in_a), longint'(inv_in_b), PC, 1'b1);
        b1 = lstep(longint'(inv_in_b), a1, UC, 1'b1);
        a2 = lstep(a1, b1, PC, 1'b1);
        iq_v.push_back(inv_in_valid); iq_a.push_back(a2); iq_b.push_back(b1);
    endtask

    function automatic longint rnd_in();
        return longint'($urandom_range(0, (1 << IN_W) - 1)) + IN_MIN;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        // R6: reset state
        repeat (4) begin
            @(negedge clk);
            check("R6", "fwd valid in reset", longint'(fwd_out_valid), 0);
            check("R6", "inv valid in reset", longint'(inv_out_valid), 0);
            check("R6", "fwd a in reset", longint'(fwd_out_a), 0);
            check("R6", "inv b in reset", longint'(inv_out_b), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R6", "fwd valid after release", longint'(fwd_out_valid), 0);
        check("R6", "inv a after release", longint'(inv_out_a), 0);

        // R7: extreme corners, back to back
        tag_fdata = "R7"; tag_valid = "R8";
        foreach (fq_v[i]) ;
        for (int i = 0; i < 9; i++) begin
            longint va, vb;
            va = (i % 3 == 0) ? IN_MAX : (i % 3 == 1) ? IN_MIN : 0;
            vb = (i / 3 == 0) ? IN_MAX : (i / 3 == 1) ? IN_MIN : -1;
            cycle(1'b1, va, vb, 1'b0, 0, 0);
        end
        repeat (8) cycle(1'b0, 0, 0, 1'b0, 0, 0);

        // R5: small negative values where floor and truncation to zero differ
        tag_fdata = "R5"; tag_valid = "R8";
        for (int i = 0; i < 40; i++) begin
            cycle(1'b1, -longint'($urandom_range(1, 20)), -longint'($urandom_range(1, 20)),
                  1'b0, 0, 0);
        end
        repeat (8) cycle(1'b0, 0, 0, 1'b0, 0, 0);

        // R1, R3, R4: random full range with random gaps
        tag_fdata = "R1"; tag_valid = "R4";
        for (int i = 0; i < 3000; i++) begin
            cycle($urandom_range(0, 3) != 0, rnd_in(), rnd_in(), 1'b0, 0, 0);
        end
        // R8: unbroken stream
        tag_valid = "R8";
        for (int i = 0; i < 500; i++) begin
            cycle(1'b1, rnd_in(), rnd_in(), 1'b0, 0, 0);
        end
        repeat (8) cycle(1'b0, 0, 0, 1'b0, 0, 0);

        // R2: inverse driven directly with arbitrary pairs
        direct_mode = 1'b1;
        tag_valid = "R4";
        for (int i = 0; i < 1500; i++) begin
            cycle(1'b0, 0, 0, $urandom_range(0, 4) != 0, rnd_in(), rnd_in());
        end
        repeat (8) cycle(1'b0, 0, 0, 1'b0, 0, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule